// File: doc/BRIEF.md
# Branch and Jump Resolution Unit

This block settles the outcome of a decoded control-transfer operation. It takes the operation code, a "likely" qualifier, the two source register values, the current PC, a sign-extended displacement counted in words, and a 26-bit absolute jump field. From these it works out whether control transfers, the address of the next instruction, whether the instruction in the delay slot must be annulled, and for the linking forms the return address and the register that receives it. A configuration input selects whether the pipeline it serves has architectural delay slots. That setting changes the return address, the branch target offset and the annul behaviour.

The unit resolves the operation combinationally and presents the result through one register stage. A result therefore appears exactly one cycle after an operation is offered with `op_valid`. The single-cycle flags (`taken`, `annul`, `link_en`) are high only in the cycle in which `res_valid` is high. Register file reads and instruction fetch are handled elsewhere.

Top module: `brj_resolve`

## Requirements
- R1: While reset is asserted and until the first operation is accepted after it, `res_valid`, `taken`, `annul`, `link_en`, `next_pc`, `link_reg` and `link_val` are all zero.
- R2: `res_valid` is high in the cycle after `op_valid` was high and low otherwise. In a cycle without `res_valid`, `taken`, `annul` and `link_en` are low, so each of them lasts one cycle per operation.
- R3: The branch conditions use these `op` codes and compare `rs_val` (with `rt_val` for the first two) as a two's-complement value:
  - 0: equal.
  - 1: not equal.
  - 2 and 6: greater than or equal to zero.
  - 3: greater than zero.
  - 4: less than or equal to zero.
  - 5 and 7: less than zero.

  `taken` is high exactly when the condition holds.
- R4: A taken branch gives `next_pc` = `pc` + 4 × `disp`, plus a further 4 when `delay_en` is 1.
- R5: A branch that is not taken, with `likely` = 0 or `delay_en` = 0, gives `next_pc` = `pc` + 4 and `annul` = 0.
- R6: A branch that is not taken, with `likely` = 1 and `delay_en` = 1, gives `next_pc` = `pc` + 8 and `annul` = 1. `annul` is never high for a taken operation or a jump.
- R7: Codes 8 and 9 (absolute jumps) are always taken. They give `next_pc` = {`pc`[31:28], `jtarget`, 2'b00}.
- R8: Codes 10 and 11 (register jumps) are always taken. They give `next_pc` = `rs_val`.
- R9: For a linking operation, `link_val` = `pc` + 8 when `delay_en` is 1 and `pc` + 4 when it is 0.
- R10: Codes 6, 7 and 9 link to register 31, code 11 links to `rd_idx`, and all other codes give `link_en` = 0. The branch-and-link codes link whether or not they are taken.
- R11: `likely` has no effect on codes 8 to 11. Codes 12 to 15 are not taken, give `next_pc` = `pc` + 4, and neither link nor annul.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is offered this cycle |
| op | input | 4 | Operation code (see R3, R7, R8, R11) |
| likely | input | 1 | Annul the delay slot when a conditional branch is not taken |
| delay_en | input | 1 | 1 when delay slots are architectural |
| rs_val | input | 32 | First source register value |
| rt_val | input | 32 | Second source register value |
| pc | input | 32 | Address of the control-transfer instruction |
| disp | input | 32 | Sign-extended branch displacement in words |
| jtarget | input | 26 | Absolute jump field |
| rd_idx | input | 5 | Destination register for the register jump-and-link |
| res_valid | output | 1 | Result present this cycle |
| taken | output | 1 | Control transfers |
| next_pc | output | 32 | Address of the next instruction to fetch |
| annul | output | 1 | Delay-slot instruction is skipped |
| link_en | output | 1 | A return address is to be written |
| link_reg | output | 5 | Register receiving the return address |
| link_val | output | 32 | Return address |

## Verification
The bench builds the unit with its default parameters: 32-bit data, 4-byte words, a 26-bit jump field and register 31 as the fixed link register. With these values the sign-boundary operands 0x8000_0000, 0x7FFF_FFFF, 0 and all-ones can be reached. So can the PC region bits [31:28] that an absolute jump keeps, and the wrap-around of negative displacements. Each operation code is run with `delay_en` both set and clear. This brings the target offset, the return address and the annul rule under each delay-slot setting.

// File: rtl/brj_pkg.sv
package brj_pkg;

  typedef enum logic [3:0] {
    OP_EQ        = 4'd0,
    OP_NE        = 4'd1,
    OP_GEZ       = 4'd2,
    OP_GTZ       = 4'd3,
    OP_LEZ       = 4'd4,
    OP_LTZ       = 4'd5,
    OP_GEZ_LINK  = 4'd6,
    OP_LTZ_LINK  = 4'd7,
    OP_JABS      = 4'd8,
    OP_JABS_LINK = 4'd9,
    OP_JREG      = 4'd10,
    OP_JREG_LINK = 4'd11
  } brj_op_e;

  localparam int OP_W = 4;

endpackage

// File: rtl/brj_cond.sv
module brj_cond
  import brj_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [OP_W-1:0] op,
  input  logic [XLEN-1:0] a_val,
  input  logic [XLEN-1:0] b_val,
  output logic            cond_hold,
  output logic            is_branch,
  output logic            is_jabs,
  output logic            is_jreg
);

  logic sgn;
  logic zro;
  logic eqv;

  assign sgn = a_val[XLEN-1];
  assign zro = (a_val == '0);
  assign eqv = (a_val == b_val);

  always_comb begin
    cond_hold = 1'b0;
    is_branch = 1'b0;
    is_jabs   = 1'b0;
    is_jreg   = 1'b0;
    case (op)
      OP_EQ:                    begin is_branch = 1'b1; cond_hold = eqv;          end
      OP_NE:                    begin is_branch = 1'b1; cond_hold = !eqv;         end
      OP_GEZ, OP_GEZ_LINK:      begin is_branch = 1'b1; cond_hold = !sgn;         end
      OP_GTZ:                   begin is_branch = 1'b1; cond_hold = !sgn && !zro; end
      OP_LEZ:                   begin is_branch = 1'b1; cond_hold = sgn || zro;   end
      OP_LTZ, OP_LTZ_LINK:      begin is_branch = 1'b1; cond_hold = sgn;          end
      OP_JABS, OP_JABS_LINK:    is_jabs = 1'b1;
      OP_JREG, OP_JREG_LINK:    is_jreg = 1'b1;
      default: ;
    endcase
  end

  // R3: a conditional branch cannot also be a jump
  always_comb begin
    a_r3_class_exclusive: assert ($onehot0({is_branch, is_jabs, is_jreg}));
  end

endmodule

// File: rtl/brj_target.sv
module brj_target #(
  parameter int XLEN  = 32,
  parameter int WB    = 4,
  parameter int JT_W  = 26
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] disp,
  input  logic [JT_W-1:0] jt,
  input  logic            delay_en,
  output logic [XLEN-1:0] br_tgt,
  output logic [XLEN-1:0] jabs_tgt,
  output logic [XLEN-1:0] seq_pc,
  output logic [XLEN-1:0] skip_pc
);

  localparam int SH   = $clog2(WB);
  localparam int HI_W = XLEN - JT_W - SH;

  logic [XLEN-1:0] disp_bytes;
  logic [XLEN-1:0] slot_adj;

  assign disp_bytes = disp << SH;
  assign slot_adj   = delay_en ? XLEN'(WB) : '0;
  assign seq_pc     = pc + XLEN'(WB);
  assign skip_pc    = pc + XLEN'(2 * WB);
  assign br_tgt     = pc + disp_bytes + slot_adj;
  assign jabs_tgt   = {pc[XLEN-1 -: HI_W], jt, {SH{1'b0}}};

endmodule

// File: rtl/brj_link.sv
module brj_link
  import brj_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int WB       = 4,
  parameter int RW       = 5,
  parameter int LINK_REG = 31
) (
  input  logic [OP_W-1:0] op,
  input  logic [XLEN-1:0] pc,
  input  logic            delay_en,
  input  logic [RW-1:0]   rd_idx,
  output logic            link_en,
  output logic [RW-1:0]   link_reg,
  output logic [XLEN-1:0] link_val
);

  localparam logic [RW-1:0] FIXED_REG = RW'(LINK_REG);

  always_comb begin
    link_en  = 1'b0;
    link_reg = '0;
    case (op)
      OP_GEZ_LINK, OP_LTZ_LINK, OP_JABS_LINK: begin
        link_en  = 1'b1;
        link_reg = FIXED_REG;
      end
      OP_JREG_LINK: begin
        link_en  = 1'b1;
        link_reg = rd_idx;
      end
      default: ;
    endcase
  end

  assign link_val = pc + (delay_en ? XLEN'(2 * WB) : XLEN'(WB));

endmodule

// File: rtl/brj_resolve.sv
module brj_resolve
  import brj_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int WB       = 4,
  parameter int JT_W     = 26,
  parameter int RW       = 5,
  parameter int LINK_REG = 31,
  parameter int SYNC_N   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [3:0]      op,
  input  logic            likely,
  input  logic            delay_en,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] disp,
  input  logic [JT_W-1:0] jtarget,
  input  logic [RW-1:0]   rd_idx,
  output logic            res_valid,
  output logic            taken,
  output logic [XLEN-1:0] next_pc,
  output logic            annul,
  output logic            link_en,
  output logic [RW-1:0]   link_reg,
  output logic [XLEN-1:0] link_val
);

  // reset: asserted asynchronously, released through a synchronizer
  logic [SYNC_N-1:0] rst_sync;
  logic              rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_N-2:0], 1'b1};
  end
  assign rst_n_s = rst_sync[SYNC_N-1];

  // combinational resolution
  logic            cond_hold, is_branch, is_jabs, is_jreg;
  logic [XLEN-1:0] br_tgt, jabs_tgt, seq_pc, skip_pc;
  logic            lnk_en_c;
  logic [RW-1:0]   lnk_reg_c;
  logic [XLEN-1:0] lnk_val_c;

  brj_cond #(.XLEN(XLEN)) u_cond (
    .op        (op),
    .a_val     (rs_val),
    .b_val     (rt_val),
    .cond_hold (cond_hold),
    .is_branch (is_branch),
    .is_jabs   (is_jabs),
    .is_jreg   (is_jreg)
  );

  brj_target #(.XLEN(XLEN), .WB(WB), .JT_W(JT_W)) u_target (
    .pc       (pc),
    .disp     (disp),
    .jt       (jtarget),
    .delay_en (delay_en),
    .br_tgt   (br_tgt),
    .jabs_tgt (jabs_tgt),
    .seq_pc   (seq_pc),
    .skip_pc  (skip_pc)
  );

  brj_link #(.XLEN(XLEN), .WB(WB), .RW(RW), .LINK_REG(LINK_REG)) u_link (
    .op       (op),
    .pc       (pc),
    .delay_en (delay_en),
    .rd_idx   (rd_idx),
    .link_en  (lnk_en_c),
    .link_reg (lnk_reg_c),
    .link_val (lnk_val_c)
  );

  // next-state
  logic            taken_d, annul_d;
  logic [XLEN-1:0] next_d;

  always_comb begin
    taken_d = 1'b0;
    annul_d = 1'b0;
    next_d  = seq_pc;
    if (is_jabs) begin
      taken_d = 1'b1;
      next_d  = jabs_tgt;
    end else if (is_jreg) begin
      taken_d = 1'b1;
      next_d  = rs_val;
    end else if (is_branch) begin
      if (cond_hold) begin
        taken_d = 1'b1;
        next_d  = br_tgt;
      end else if (likely && delay_en) begin
        annul_d = 1'b1;
        next_d  = skip_pc;
      end
    end
  end

  // registers: flags follow op_valid, data fields load under op_valid
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      res_valid <= 1'b0;
      taken     <= 1'b0;
      annul     <= 1'b0;
      link_en   <= 1'b0;
      next_pc   <= '0;
      link_reg  <= '0;
      link_val  <= '0;
    end else begin
      res_valid <= op_valid;
      taken     <= op_valid && taken_d;
      annul     <= op_valid && annul_d;
      link_en   <= op_valid && lnk_en_c;
      if (op_valid) begin
        next_pc  <= next_d;
        link_reg <= lnk_reg_c;
        link_val <= lnk_val_c;
      end
    end
  end

  // assertion qualifier: one full cycle out of reset so $past is meaningful
  logic armed;
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) armed <= 1'b0;
    else          armed <= 1'b1;
  end

  // R2: a result appears exactly one cycle after an offer
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n_s || !armed)
    res_valid == $past(op_valid));

  // R2: single-cycle flags stay low without a result
  a_r2_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n_s || !armed)
    !res_valid |-> (!taken && !annul && !link_en));

  // R6: annul only for a non-taken likely operation with delay slots on
  a_r6_annul_rule: assert property (@(posedge clk) disable iff (!rst_n_s || !armed)
    annul |-> (!taken && $past(likely) && $past(delay_en)
               && (next_pc == $past(pc) + XLEN'(2 * WB))));

  // R5: a non-taken, non-annulled result falls through one word
  a_r5_fallthrough: assert property (@(posedge clk) disable iff (!rst_n_s || !armed)
    (res_valid && !taken && !annul) |-> (next_pc == $past(pc) + XLEN'(WB)));

  // R7 / R8: jump codes always transfer
  a_r7_jump_taken: assert property (@(posedge clk) disable iff (!rst_n_s || !armed)
    (op_valid && op[3] && !op[2]) |=> (taken && !annul));

  // R9: the return address tracks the delay-slot setting
  a_r9_link_value: assert property (@(posedge clk) disable iff (!rst_n_s || !armed)
    link_en |-> (link_val == $past(pc) + ($past(delay_en) ? XLEN'(2 * WB) : XLEN'(WB))));

endmodule

// File: tb/brj_resolve_bench.sv
`timescale 1ns/1ps
module brj_resolve_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  op;
  logic        likely;
  logic        delay_en;
  logic [31:0] rs_val, rt_val, pc, disp;
  logic [25:0] jtarget;
  logic [4:0]  rd_idx;
  logic        res_valid, taken, annul, link_en;
  logic [31:0] next_pc, link_val;
  logic [4:0]  link_reg;

  always #5 clk = ~clk;

  brj_resolve u_brj_resolve (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .likely(likely),
    .delay_en(delay_en), .rs_val(rs_val), .rt_val(rt_val), .pc(pc), .disp(disp),
    .jtarget(jtarget), .rd_idx(rd_idx), .res_valid(res_valid), .taken(taken),
    .next_pc(next_pc), .annul(annul), .link_en(link_en), .link_reg(link_reg),
    .link_val(link_val)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // pending expectation for the next negedge
  bit          p_have;
  bit          p_valid;
  bit          e_taken, e_annul, e_link_en;
  logic [31:0] e_next, e_link_val;
  logic [4:0]  e_link_reg;
  string       t_taken, t_next;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // behavioural reference
  task automatic model(input bit v, input int code, input bit lk, input bit de,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] p, input logic [31:0] d,
                       input logic [25:0] j, input logic [4:0] r);
    bit c;
    longint sa;
    p_have = 1; p_valid = v;
    e_taken = 0; e_annul = 0; e_link_en = 0; e_link_reg = 0;
    e_next = p + 4;
    e_link_val = p + (de ? 8 : 4);
    t_taken = "R3"; t_next = "R5";
    sa = longint'($signed(a));
    c = 0;
    case (code)
      0: c = (a == b);
      1: c = (a != b);
      2, 6: c = (sa >= 0);
      3: c = (sa > 0);
      4: c = (sa <= 0);
      5, 7: c = (sa < 0);
      default: c = 0;
    endcase
    if (code <= 7) begin
      if (c) begin
        e_taken = 1; e_next = p + d * 4 + (de ? 4 : 0); t_next = "R4";
      end else if (lk && de) begin
        e_annul = 1; e_next = p + 8; t_next = "R6";
      end else if (lk) t_next = "R6";
    end else if (code == 8 || code == 9) begin
      e_taken = 1; e_next = (p & 32'hF000_0000) | ({6'd0, j} * 4);
      t_taken = "R7"; t_next = lk ? "R11" : "R7";
    end else if (code == 10 || code == 11) begin
      e_taken = 1; e_next = a; t_taken = "R8"; t_next = lk ? "R11" : "R8";
    end else begin
      t_taken = "R11"; t_next = "R11";
    end
    if (code == 6 || code == 7 || code == 9) begin e_link_en = 1; e_link_reg = 5'd31; end
    if (code == 11) begin e_link_en = 1; e_link_reg = r; end
  endtask

  task automatic compare();
    if (!p_have) return;
    chk(res_valid == p_valid, "R2", "res_valid", 32'(res_valid), 32'(p_valid));
    if (!p_valid) begin
      chk(!taken && !annul && !link_en, "R2", "flags idle",
          {29'd0, taken, annul, link_en}, 32'd0);
    end else begin
      chk(taken == e_taken, t_taken, "taken", 32'(taken), 32'(e_taken));
      chk(next_pc == e_next, t_next, "next_pc", next_pc, e_next);
      chk(annul == e_annul, "R6", "annul", 32'(annul), 32'(e_annul));
      chk(link_en == e_link_en, "R10", "link_en", 32'(link_en), 32'(e_link_en));
      if (e_link_en) begin
        chk(link_reg == e_link_reg, "R10", "link_reg", 32'(link_reg), 32'(e_link_reg));
        chk(link_val == e_link_val, "R9", "link_val", link_val, e_link_val);
      end
    end
  endtask

  task automatic step(input bit v, input int code, input bit lk, input bit de,
                      input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] p, input logic [31:0] d,
                      input logic [25:0] j, input logic [4:0] r);
    @(negedge clk);
    compare();
    op_valid = v; op = 4'(code); likely = lk; delay_en = de;
    rs_val = a; rt_val = b; pc = p; disp = d; jtarget = j; rd_idx = r;
    model(v, code, lk, de, a, b, p, d, j, r);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    p_have = 0;
    rst_n = 0; op_valid = 0; op = 0; likely = 0; delay_en = 0;
    rs_val = 0; rt_val = 0; pc = 0; disp = 0; jtarget = 0; rd_idx = 0;
    repeat (3) @(negedge clk);
    chk(!res_valid && !taken && !annul && !link_en && next_pc == 0 &&
        link_reg == 0 && link_val == 0, "R1", "reset outputs",
        {28'd0, res_valid, taken, annul, link_en} | next_pc | link_val, 32'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!res_valid && next_pc == 0 && link_val == 0, "R1", "after release",
        next_pc | link_val | 32'(res_valid), 32'd0);

    // R3 conditions at sign boundaries, both delay settings
    for (int de = 0; de < 2; de++) begin
      step(1, 0, 0, de[0], 32'h1234, 32'h1234, 32'h0000_1000, 32'd4, 0, 0);
      step(1, 0, 0, de[0], 32'h1234, 32'h1235, 32'h0000_1000, 32'd4, 0, 0);
      step(1, 1, 0, de[0], 32'h8000_0000, 32'h0, 32'h0000_2000, 32'hFFFF_FFFC, 0, 0);
      step(1, 1, 0, de[0], 32'h7, 32'h7, 32'h0000_2000, 32'd1, 0, 0);
      step(1, 2, 0, de[0], 32'h0, 0, 32'h100, 32'd3, 0, 0);
      step(1, 2, 0, de[0], 32'h8000_0000, 0, 32'h100, 32'd3, 0, 0);
      step(1, 3, 0, de[0], 32'h0, 0, 32'h200, 32'd2, 0, 0);
      step(1, 3, 0, de[0], 32'h7FFF_FFFF, 0, 32'h200, 32'd2, 0, 0);
      step(1, 4, 0, de[0], 32'h0, 0, 32'h300, 32'hFFFF_FFFF, 0, 0);
      step(1, 4, 0, de[0], 32'h1, 0, 32'h300, 32'hFFFF_FFFF, 0, 0);
      step(1, 5, 0, de[0], 32'hFFFF_FFFF, 0, 32'h400, 32'd8, 0, 0);
      step(1, 5, 0, de[0], 32'h0, 0, 32'h400, 32'd8, 0, 0);
      // R10 branch-and-link, taken and not taken
      step(1, 6, 0, de[0], 32'h5, 0, 32'h500, 32'd6, 0, 0);
      step(1, 6, 0, de[0], 32'hF000_0000, 0, 32'h500, 32'd6, 0, 0);
      step(1, 7, 0, de[0], 32'hF000_0000, 0, 32'h600, 32'd6, 0, 0);
      step(1, 7, 0, de[0], 32'h1, 0, 32'h600, 32'd6, 0, 0);
      // R6 likely: not taken annuls only with delay slots, taken does not
      step(1, 0, 1, de[0], 32'h1, 32'h2, 32'h700, 32'd5, 0, 0);
      step(1, 0, 1, de[0], 32'h3, 32'h3, 32'h700, 32'd5, 0, 0);
      step(1, 7, 1, de[0], 32'h3, 0, 32'h740, 32'd5, 0, 0);
      // R7 absolute jumps keep the PC region bits
      step(1, 8, 0, de[0], 0, 0, 32'hA000_0010, 0, 26'h3FF_FFFF, 0);
      step(1, 9, 1, de[0], 0, 0, 32'h5FFF_FFF0, 0, 26'h000_0001, 0);
      // R8 register jumps
      step(1, 10, 1, de[0], 32'hDEAD_BEE0, 0, 32'h800, 0, 0, 5'd9);
      step(1, 11, 0, de[0], 32'h0000_4000, 0, 32'h900, 0, 0, 5'd7);
      // R11 undefined codes, R2 idle gap
      step(1, 13, 1, de[0], 32'h1, 32'h1, 32'hA00, 32'd9, 26'h55, 5'd3);
      step(0, 0, 0, de[0], 32'h1, 32'h1, 32'hB00, 32'd9, 0, 0);
      step(0, 9, 1, de[0], 32'h1, 32'h1, 32'hB00, 32'd9, 0, 0);
    end

    // mixed pseudo-random operations
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = ($urandom_range(0, 3) == 0) ? a : $urandom;
      if ($urandom_range(0, 7) == 0) a = 0;
      step($urandom_range(0, 5) != 0, int'($urandom_range(0, 15)),
           1'($urandom), 1'($urandom), a, b, {$urandom} & 32'hFFFF_FFFC,
           ($urandom_range(0, 1) != 0) ? 32'($signed(16'($urandom))) : 32'($urandom_range(0, 64)),
           26'($urandom), 5'($urandom));
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    compare();
    summary();
  end

endmodule